// File: doc/BRIEF.md
# Reset Sequencing Controller

This block merges every source of chip reset into one chip-reset output and keeps that output high until the start-up delays have run out. The sources are a power-on detect, an active-low external reset pin, a watchdog time-out and a brown-out detect that can be switched off. Supply-level detection is done elsewhere, so each source arrives here as a digital level or pulse. The pin goes through a glitch filter before it is accepted. A watchdog time-out is treated in one of two ways. If the core is asleep it is only a wake-up, and reset is not asserted. If the core is running it is a reset.

Release is timed by two 10-bit start-up counters. The power-up counter advances on ticks from a separate on-chip RC oscillator, and the oscillator start-up counter advances on ticks from the external oscillator. A set/reset latch holds chip reset. Any source sets the latch, and the latch clears once every enabled counter has rolled over. Two status bits, time-out and power-down, and a cause code let software tell afterwards which event occurred.

The power-on input also acts as the synchronous reset of the block. The block has no output that drives the external pin, so a watchdog reset affects only the internal chip reset.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por` is high, each clock edge leaves `chip_rst`=1, `to_flag`=1, `pd_flag`=1 and `rst_cause`=0.
- R2: The pin reset is accepted only after `ext_rst_n` has been sampled low on FILT_LEN consecutive edges (FILT_LEN defaults to 4). `chip_rst` rises on the next edge. A shorter low pulse has no effect on any output.
- R3: `wdt_expire` sampled while `core_sleep`=0 sets `chip_rst`, `to_flag`=0, `pd_flag`=1 and `rst_cause`=4.
- R4: `wdt_expire` sampled while `core_sleep`=1 leaves `chip_rst` low. It raises `wdt_wake` for exactly one cycle and gives `to_flag`=0, `pd_flag`=0 and `rst_cause`=5.
- R5: An accepted pin reset while `core_sleep`=0 sets `chip_rst` and gives `rst_cause`=2. `to_flag` and `pd_flag` keep their values.
- R6: An accepted pin reset while `core_sleep`=1 sets `chip_rst` and gives `to_flag`=1, `pd_flag`=0 and `rst_cause`=3.
- R7: `bod_det` has no effect while `bod_en`=0. With `bod_en`=1 it sets `chip_rst` and gives `to_flag`=1, `pd_flag`=1 and `rst_cause`=1.
- R8: `chip_rst` falls on the edge after every enabled counter has seen its 1024th tick since the last active source. A counter whose enable is low counts as already done. With both enables low, `chip_rst` falls on the first edge at which no source is active.
- R9: Ticks are counted only while `chip_rst` is high and no source is active. A source that returns while the counters are running restarts both counters from zero.
- R10: When sources coincide, the status follows the priority brown-out, then pin, then watchdog. A pin reset in sleep together with a watchdog time-out gives cause 3 and no wake pulse. A pin reset while running together with a watchdog time-out gives cause 2 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, which also samples the pin filter |
| por | input | 1 | Power-on detect, active high; synchronous reset of the block |
| ext_rst_n | input | 1 | External reset pin, active low, before filtering |
| bod_det | input | 1 | Brown-out detect level |
| bod_en | input | 1 | Enables the brown-out reset path |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| core_sleep | input | 1 | Core is in sleep mode |
| pwrt_en | input | 1 | Enables the power-up counter |
| pwrt_tick | input | 1 | Tick from the on-chip RC oscillator |
| ost_en | input | 1 | Enables the oscillator start-up counter |
| ost_tick | input | 1 | Tick from the external oscillator |
| chip_rst | output | 1 | Chip reset, active high |
| wdt_wake | output | 1 | One-cycle pulse on a watchdog wake-up from sleep |
| to_flag | output | 1 | Time-out status bit |
| pd_flag | output | 1 | Power-down status bit |
| rst_cause | output | 3 | Last event: 0 power-on, 1 brown-out, 2 pin while running, 3 pin in sleep, 4 watchdog while running, 5 watchdog wake |

## Verification
The watchdog time-out and an accepted pin reset can fall on the same clock edge, and they resolve differently depending on sleep. The bench holds the pin low until the filter has just accepted it and then fires the watchdog on that same edge, once in sleep and once while running. It then checks that the cause, the flags and the absence of a wake pulse follow the pin. Brown-out together with a watchdog reset is provoked the same way, and the expected result is the brown-out encoding.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int TMR_W    = 10;
    localparam int FILT_LEN = 4;

    typedef enum logic [2:0] {
        CAUSE_POR       = 3'd0,
        CAUSE_BOR       = 3'd1,
        CAUSE_PIN_RUN   = 3'd2,
        CAUSE_PIN_SLEEP = 3'd3,
        CAUSE_WDT_RUN   = 3'd4,
        CAUSE_WDT_WAKE  = 3'd5
    } cause_e;

    typedef struct packed {
        logic   to;
        logic   pd;
        cause_e cause;
    } status_t;

    typedef struct packed {
        logic bor;
        logic pin_run;
        logic pin_sleep;
        logic wdt_run;
        logic wdt_wake;
    } events_t;

    localparam status_t STATUS_POR = '{to: 1'b1, pd: 1'b1, cause: CAUSE_POR};

    // Priority: brown-out, then pin, then watchdog.
    function automatic status_t next_status(status_t cur, events_t ev);
        status_t n;
        n = cur;
        if (ev.bor) begin
            n.to = 1'b1; n.pd = 1'b1; n.cause = CAUSE_BOR;
        end else if (ev.pin_sleep) begin
            n.to = 1'b1; n.pd = 1'b0; n.cause = CAUSE_PIN_SLEEP;
        end else if (ev.pin_run) begin
            n.cause = CAUSE_PIN_RUN;
        end else if (ev.wdt_run) begin
            n.to = 1'b0; n.pd = 1'b1; n.cause = CAUSE_WDT_RUN;
        end else if (ev.wdt_wake) begin
            n.to = 1'b0; n.pd = 1'b0; n.cause = CAUSE_WDT_WAKE;
        end
        return n;
    endfunction

    function automatic logic wake_only(events_t ev);
        return ev.wdt_wake && !ev.bor && !ev.pin_run && !ev.pin_sleep;
    endfunction

endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic pin_n,
    output logic accepted
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (clr || pin_n) begin
            low_cnt <= '0;
        end else if (low_cnt != FULL) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign accepted = (low_cnt == FULL);
endmodule

// File: rtl/rstseq_startup_tmr.sv
module rstseq_startup_tmr #(
    parameter int W = 10
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    input  logic run,
    input  logic tick,
    output logic done
);
    logic [W-1:0] cnt;
    logic         fin;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
            fin <= 1'b0;
        end else if (run && en && !fin && tick) begin
            cnt <= cnt + 1'b1;
            if (cnt == {W{1'b1}}) begin
                fin <= 1'b1;
            end
        end
    end

    assign done = fin || !en;
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic    clk,
    input  logic    por,
    input  events_t ev,
    output status_t stat,
    output logic    wake
);
    always_ff @(posedge clk) begin
        if (por) begin
            stat <= STATUS_POR;
            wake <= 1'b0;
        end else begin
            stat <= next_status(stat, ev);
            wake <= wake_only(ev);
        end
    end
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int TMR_BITS  = rstseq_pkg::TMR_W,
    parameter int PIN_FILT  = rstseq_pkg::FILT_LEN
) (
    input  logic       clk,
    input  logic       por,
    input  logic       ext_rst_n,
    input  logic       bod_det,
    input  logic       bod_en,
    input  logic       wdt_expire,
    input  logic       core_sleep,
    input  logic       pwrt_en,
    input  logic       pwrt_tick,
    input  logic       ost_en,
    input  logic       ost_tick,
    output logic       chip_rst,
    output logic       wdt_wake,
    output logic       to_flag,
    output logic       pd_flag,
    output logic [2:0] rst_cause
);
    localparam int NTMR = 2;

    logic            pin_rst;
    logic            src_any;
    logic            tmr_clr;
    logic            all_done;
    logic            rst_q;
    events_t         ev;
    status_t         stat;
    logic [NTMR-1:0] t_en, t_tick, t_done;

    rstseq_pin_filter #(.FILT_LEN(PIN_FILT)) u_filt (
        .clk      (clk),
        .clr      (por),
        .pin_n    (ext_rst_n),
        .accepted (pin_rst)
    );

    always_comb begin
        ev.bor       = bod_det && bod_en;
        ev.pin_run   = pin_rst && !core_sleep;
        ev.pin_sleep = pin_rst && core_sleep;
        ev.wdt_run   = wdt_expire && !core_sleep;
        ev.wdt_wake  = wdt_expire && core_sleep;
    end

    assign src_any = ev.bor || pin_rst || ev.wdt_run;
    assign tmr_clr = por || src_any;

    assign t_en   = {ost_en, pwrt_en};
    assign t_tick = {ost_tick, pwrt_tick};

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        rstseq_startup_tmr #(.W(TMR_BITS)) u_tmr (
            .clk  (clk),
            .clr  (tmr_clr),
            .en   (t_en[g]),
            .run  (rst_q),
            .tick (t_tick[g]),
            .done (t_done[g])
        );
    end

    assign all_done = &t_done;

    // Set/reset latch: setting wins over clearing.
    always_ff @(posedge clk) begin
        if (por || src_any) begin
            rst_q <= 1'b1;
        end else if (all_done) begin
            rst_q <= 1'b0;
        end
    end

    rstseq_status u_stat (
        .clk  (clk),
        .por  (por),
        .ev   (ev),
        .stat (stat),
        .wake (wdt_wake)
    );

    assign chip_rst  = rst_q;
    assign to_flag   = stat.to;
    assign pd_flag   = stat.pd;
    assign rst_cause = stat.cause;
endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk (
    input logic       clk,
    input logic       por,
    input logic       ext_rst_n,
    input logic       bod_det,
    input logic       bod_en,
    input logic       wdt_expire,
    input logic       core_sleep,
    input logic       chip_rst,
    input logic       wdt_wake,
    input logic       to_flag,
    input logic       pd_flag,
    input logic       pin_rst,
    input logic       tmr_done
);
    logic seen;
    logic por_d;
    logic bor_act;

    assign bor_act = bod_det && bod_en;

    always_ff @(posedge clk) begin
        seen  <= 1'b1;
        por_d <= por;
    end

    // R1
    always_ff @(posedge clk) begin
        if (seen === 1'b1 && por_d === 1'b1) begin
            por_state_chk: assert (chip_rst && to_flag && pd_flag);
        end
    end

    // R2
    pin_filter_chk: assert property (@(posedge clk) disable iff (por)
        pin_rst |-> !$past(ext_rst_n));

    // R3
    wdt_run_chk: assert property (@(posedge clk) disable iff (por)
        (wdt_expire && !core_sleep && !bor_act && !pin_rst)
        |=> (chip_rst && !to_flag && pd_flag));

    // R4
    wdt_wake_chk: assert property (@(posedge clk) disable iff (por)
        (wdt_expire && core_sleep && !bor_act && !pin_rst && !chip_rst)
        |=> (!chip_rst && wdt_wake && !to_flag && !pd_flag));

    // R5
    pin_run_chk: assert property (@(posedge clk) disable iff (por)
        (pin_rst && !core_sleep && !bor_act)
        |=> (chip_rst && $stable(to_flag) && $stable(pd_flag)));

    // R7
    bor_off_chk: assert property (@(posedge clk) disable iff (por)
        (bod_det && !bod_en && !pin_rst && !wdt_expire && !chip_rst)
        |=> !chip_rst);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (por)
        $fell(chip_rst) |-> $past(tmr_done));
endmodule

bind rstseq_ctrl rstseq_ctrl_chk u_chk (
    .clk        (clk),
    .por        (por),
    .ext_rst_n  (ext_rst_n),
    .bod_det    (bod_det),
    .bod_en     (bod_en),
    .wdt_expire (wdt_expire),
    .core_sleep (core_sleep),
    .chip_rst   (chip_rst),
    .wdt_wake   (wdt_wake),
    .to_flag    (to_flag),
    .pd_flag    (pd_flag),
    .pin_rst    (pin_rst),
    .tmr_done   (all_done)
);

// File: tb/rstseq_ctrl_tb.sv
module rstseq_ctrl_tb_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic por, ext_rst_n, bod_det, bod_en, wdt_expire, core_sleep;
    logic pwrt_en, pwrt_tick, ost_en, ost_tick;
    logic chip_rst, wdt_wake, to_flag, pd_flag;
    logic [2:0] rst_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic       rst;
        logic       to;
        logic       pd;
        logic       wk;
        logic [2:0] cause;
        string      req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    rstseq_ctrl dut_i (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .bod_det(bod_det),
        .bod_en(bod_en), .wdt_expire(wdt_expire), .core_sleep(core_sleep),
        .pwrt_en(pwrt_en), .pwrt_tick(pwrt_tick), .ost_en(ost_en),
        .ost_tick(ost_tick), .chip_rst(chip_rst), .wdt_wake(wdt_wake),
        .to_flag(to_flag), .pd_flag(pd_flag), .rst_cause(rst_cause)
    );

    // Monitor: compares after each edge for which an item was queued.
    always @(posedge clk) begin
        #(CLK_P/4);
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (chip_rst !== e.rst || to_flag !== e.to || pd_flag !== e.pd ||
                wdt_wake !== e.wk || rst_cause !== e.cause) begin
                errors++;
                $display("FAIL %s: actual rst=%b to=%b pd=%b wake=%b cause=%0d expected rst=%b to=%b pd=%b wake=%b cause=%0d",
                         e.req, chip_rst, to_flag, pd_flag, wdt_wake, rst_cause,
                         e.rst, e.to, e.pd, e.wk, e.cause);
            end
        end
    end

    // Driver: inputs already set; optionally queue the result expected after the next edge.
    task automatic cyc(input bit chk, input logic r, input logic t, input logic p,
                       input logic w, input logic [2:0] c, input string req);
        if (chk) begin
            exp_t e;
            e.rst = r; e.to = t; e.pd = p; e.wk = w; e.cause = c; e.req = req;
            exp_q.push_back(e);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, "");
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        por = 1; ext_rst_n = 1; bod_det = 0; bod_en = 0; wdt_expire = 0;
        core_sleep = 0; pwrt_en = 1; pwrt_tick = 0; ost_en = 1; ost_tick = 0;
        @(negedge clk);
        cyc(1, 1, 1, 1, 0, 0, "R1");
        por = 0;
        // R9: no ticks, reset held
        for (int i = 0; i < 5; i++) cyc(1, 1, 1, 1, 0, 0, "R9");
        // R8: both counters enabled
        pwrt_tick = 1; idle(1024);
        pwrt_tick = 0; ost_tick = 1; idle(1023);
        cyc(1, 1, 1, 1, 0, 0, "R8");
        ost_tick = 0;
        cyc(1, 0, 1, 1, 0, 0, "R8");
        pwrt_en = 0; ost_en = 0;
        // R3
        wdt_expire = 1; cyc(1, 1, 0, 1, 0, 4, "R3");
        wdt_expire = 0; cyc(1, 0, 0, 1, 0, 4, "R8");
        // R2: short glitch
        ext_rst_n = 0;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 0, 4, "R2");
        ext_rst_n = 1; cyc(1, 0, 0, 1, 0, 4, "R2");
        // R2/R5: full-width pin reset while running
        ext_rst_n = 0;
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 1, 0, 4, "R2");
        cyc(1, 1, 0, 1, 0, 2, "R5");
        ext_rst_n = 1; cyc(1, 1, 0, 1, 0, 2, "R5");
        cyc(1, 0, 0, 1, 0, 2, "R8");
        // R4: watchdog wake from sleep
        core_sleep = 1; wdt_expire = 1; cyc(1, 0, 0, 0, 1, 5, "R4");
        wdt_expire = 0; cyc(1, 0, 0, 0, 0, 5, "R4");
        // R6: pin reset in sleep
        ext_rst_n = 0;
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 5, "R6");
        cyc(1, 1, 1, 0, 0, 3, "R6");
        ext_rst_n = 1; cyc(1, 1, 1, 0, 0, 3, "R6");
        core_sleep = 0; cyc(1, 0, 1, 0, 0, 3, "R8");
        // R7: brown-out gated, then enabled
        bod_det = 1; bod_en = 0; cyc(1, 0, 1, 0, 0, 3, "R7");
        bod_en = 1; cyc(1, 1, 1, 1, 0, 1, "R7");
        bod_det = 0; cyc(1, 0, 1, 1, 0, 1, "R7");
        // R10: brown-out with watchdog reset
        bod_det = 1; wdt_expire = 1; cyc(1, 1, 1, 1, 0, 1, "R10");
        bod_det = 0; wdt_expire = 0; cyc(1, 0, 1, 1, 0, 1, "R10");
        // R10: pin in sleep with watchdog on the acceptance edge
        core_sleep = 1; ext_rst_n = 0;
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 1, 0, 1, "R10");
        wdt_expire = 1; cyc(1, 1, 1, 0, 0, 3, "R10");
        wdt_expire = 0; ext_rst_n = 1; cyc(1, 1, 1, 0, 0, 3, "R10");
        core_sleep = 0; cyc(1, 0, 1, 0, 0, 3, "R10");
        // R10: pin while running with watchdog
        ext_rst_n = 0;
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, 3, "R10");
        wdt_expire = 1; cyc(1, 1, 1, 0, 0, 2, "R10");
        wdt_expire = 0; ext_rst_n = 1; cyc(1, 1, 1, 0, 0, 2, "R10");
        cyc(1, 0, 1, 0, 0, 2, "R10");
        // R9: restart of the counter by a returning source
        pwrt_en = 1;
        wdt_expire = 1; cyc(1, 1, 0, 1, 0, 4, "R9");
        wdt_expire = 0; pwrt_tick = 1; idle(500);
        wdt_expire = 1; cyc(1, 1, 0, 1, 0, 4, "R9");
        wdt_expire = 0; idle(1023);
        cyc(1, 1, 0, 1, 0, 4, "R9");
        pwrt_tick = 0; cyc(1, 0, 0, 1, 0, 4, "R9");
        // R1: power-on while running
        por = 1; cyc(1, 1, 1, 1, 0, 0, "R1");
        por = 0; cyc(0, 0, 0, 0, 0, 0, "");
        @(negedge clk);
        finished = 1;
        summary();
    end
endmodule